// File: doc/BRIEF.md
# Saturating Multiply-Accumulate Unit

This block keeps a signed 64-bit accumulator as two 32-bit halves, an upper one and a lower one. Each request multiplies two signed operands and adds the product into the accumulator. There are two request kinds. The long kind uses the full 32-bit operands. The word kind uses only the low 16 bits of each operand, sign-extended. A per-request saturation flag selects a clipping rule, and that rule differs between the two kinds. The long kind masks only the upper half toward a 48-bit signed range. The word kind replaces the whole accumulator with a fixed pattern that has an upper half of 1 when the sum leaves the signed 32-bit range.

The multiplier is iterative. It retires `STEP_BITS` multiplier bits per cycle on operand magnitudes and applies the sign at the end. A four-state controller sequences each request through the states ST_IDLE, ST_MUL, ST_WB and ST_DONE. The transitions are:
- ST_IDLE to ST_MUL when `req_valid` is sampled high.
- ST_MUL to ST_WB when the multiplier flags its product as final.
- ST_WB to ST_DONE unconditionally. ST_WB is the cycle that writes the accumulator.
- ST_DONE to ST_IDLE unconditionally. In ST_DONE, `done` is high.

While idle, the accumulator can be cleared or either half can be loaded. Both halves are always visible on output ports.

Top module: `mac_sat_unit`

## Requirements
- R1: After reset, `acc_hi`, `acc_lo`, `busy` and `done` are all zero.
- R2: A long request (`req_word`=0) with `req_sat`=0 stores {acc_hi,acc_lo} + signed(req_a)·signed(req_b), wrapping modulo 2^64.
- R3: A word request (`req_word`=1) multiplies the sign-extended bits 15:0 of each operand; bits 31:16 have no effect.
- R4: A long request with `req_sat`=1 stores the low 32 bits of the sum in `acc_lo`. If the 64-bit sum is negative, `acc_hi` gets the upper 32 bits of the sum ORed with 0xFFFF0000; otherwise it gets them ANDed with 0x00007FFF.
- R5: A word request with `req_sat`=1 whose 64-bit sum is below -2^31 leaves `acc_hi`=1 and `acc_lo`=0x80000000.
- R6: A word request with `req_sat`=1 whose 64-bit sum exceeds 2^31-1 leaves `acc_hi`=1 and `acc_lo`=0x7FFFFFFF.
- R7: A word request whose sum is within the signed 32-bit range, or one made with `req_sat`=0, stores the plain 64-bit sum.
- R8: In an idle cycle with `req_valid` low, `clr` zeroes both halves at the next edge and takes priority over `wr_hi` and `wr_lo`.
- R9: In an idle cycle with `req_valid` low and `clr` low, `wr_hi` loads `wr_data` into `acc_hi` only, and `wr_lo` loads it into `acc_lo` only.
- R10: `done` is high for exactly one cycle per accepted request. That cycle follows the (32/STEP_BITS + 2)-th rising edge after the accepting edge. The accumulator already holds the result in that cycle.
- R11: While `busy` is high, `req_valid`, `clr`, `wr_hi` and `wr_lo` are ignored. `busy` rises only after an edge at which `req_valid` was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, accepted when idle |
| req_word | input | 1 | 1 selects word (16-bit) kind, 0 selects long kind |
| req_sat | input | 1 | Saturation mode for this request |
| req_a | input | 32 | First operand |
| req_b | input | 32 | Second operand |
| clr | input | 1 | Clear both halves (idle only) |
| wr_hi | input | 1 | Load upper half from wr_data (idle only) |
| wr_lo | input | 1 | Load lower half from wr_data (idle only) |
| wr_data | input | 32 | Load value |
| busy | output | 1 | High from acceptance through the done cycle |
| done | output | 1 | One-cycle completion pulse |
| acc_hi | output | 32 | Upper accumulator half |
| acc_lo | output | 32 | Lower accumulator half |

## Verification
The bench builds the unit with STEP_BITS=4, so the multiplier takes eight iterations and each request takes ten edges from acceptance to `done`. This leaves a window of several busy cycles in which the bench pulses clear, load and a second request to show they are ignored. The bench also reaches the boundary operands −2^31·−2^31 and a sum that wraps past the top of the 64-bit range. Halves are preloaded to sit exactly at the saturation thresholds of both kinds.

// File: rtl/mac_sat_pkg.sv
package mac_sat_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_MUL,
        ST_WB,
        ST_DONE
    } mac_state_e;
endpackage

// File: rtl/mac_mul_iter.sv
// Signed iterative multiplier: works on magnitudes, STEP_BITS multiplier bits per cycle.
module mac_mul_iter #(
    parameter int OP_W      = 32,
    parameter int STEP_BITS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [OP_W-1:0]     op_a,
    input  logic [OP_W-1:0]     op_b,
    output logic [2*OP_W-1:0]   prod,
    output logic                fin
);
    localparam int STEPS  = OP_W / STEP_BITS;
    localparam int CNT_W  = $clog2(STEPS + 1);
    localparam int PROD_W = 2 * OP_W;

    logic [OP_W-1:0]   mcand, mplier;
    logic [PROD_W-1:0] accum, partial;
    logic [CNT_W-1:0]  cnt;
    logic              neg, run;
    logic [OP_W-1:0]   a_mag, b_mag;

    always_comb begin
        a_mag   = op_a[OP_W-1] ? OP_W'(~op_a + 1'b1) : op_a;
        b_mag   = op_b[OP_W-1] ? OP_W'(~op_b + 1'b1) : op_b;
        partial = (PROD_W'(mcand) * PROD_W'(mplier[STEP_BITS-1:0])) << (STEP_BITS * int'(cnt));
        prod    = neg ? PROD_W'(~accum + 1'b1) : accum;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mcand  <= '0;
            mplier <= '0;
            accum  <= '0;
            cnt    <= '0;
            neg    <= 1'b0;
            run    <= 1'b0;
            fin    <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (start) begin
                mcand  <= a_mag;
                mplier <= b_mag;
                neg    <= op_a[OP_W-1] ^ op_b[OP_W-1];
                accum  <= '0;
                cnt    <= '0;
                run    <= 1'b1;
            end else if (run) begin
                accum  <= accum + partial;
                mplier <= mplier >> STEP_BITS;
                cnt    <= cnt + 1'b1;
                if (cnt == CNT_W'(STEPS - 1)) begin
                    run <= 1'b0;
                    fin <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/mac_sat_logic.sv
// Accumulate and apply the kind-specific clipping rule.
module mac_sat_logic #(
    parameter int HALF_W = 32
) (
    input  logic [HALF_W-1:0]   acc_hi,
    input  logic [HALF_W-1:0]   acc_lo,
    input  logic [2*HALF_W-1:0] prod,
    input  logic                word_mode,
    input  logic                sat_mode,
    output logic [HALF_W-1:0]   res_hi,
    output logic [HALF_W-1:0]   res_lo
);
    localparam int FULL_W = 2 * HALF_W;
    localparam int UP_W   = HALF_W / 2;
    localparam logic [HALF_W-1:0] MASK_UP   = {{UP_W{1'b1}}, {(HALF_W-UP_W){1'b0}}};
    localparam logic [HALF_W-1:0] MASK_KEEP = {{(HALF_W-UP_W+1){1'b0}}, {(UP_W-1){1'b1}}};
    localparam logic [FULL_W-1:0] LOW_BOUND  = {{(HALF_W+1){1'b1}}, {(HALF_W-1){1'b0}}};
    localparam logic [FULL_W-1:0] HIGH_BOUND = {{(HALF_W+1){1'b0}}, {(HALF_W-1){1'b1}}};
    localparam logic [HALF_W-1:0] ONE_HI    = HALF_W'(1);
    localparam logic [HALF_W-1:0] MIN_LO    = {1'b1, {(HALF_W-1){1'b0}}};
    localparam logic [HALF_W-1:0] MAX_LO    = {1'b0, {(HALF_W-1){1'b1}}};

    logic [FULL_W-1:0] sum;
    logic              below, above;

    always_comb begin
        sum    = {acc_hi, acc_lo} + prod;
        below  = $signed(sum) < $signed(LOW_BOUND);
        above  = $signed(sum) > $signed(HIGH_BOUND);
        res_hi = sum[FULL_W-1:HALF_W];
        res_lo = sum[HALF_W-1:0];
        if (sat_mode) begin
            if (!word_mode) begin
                if (sum[FULL_W-1]) res_hi = sum[FULL_W-1:HALF_W] | MASK_UP;
                else               res_hi = sum[FULL_W-1:HALF_W] & MASK_KEEP;
            end else if (below) begin
                res_hi = ONE_HI;
                res_lo = MIN_LO;
            end else if (above) begin
                res_hi = ONE_HI;
                res_lo = MAX_LO;
            end
        end
    end
endmodule

// File: rtl/mac_sat_unit.sv
module mac_sat_unit #(
    parameter int HALF_W    = 32,
    parameter int WORD_W    = 16,
    parameter int STEP_BITS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_word,
    input  logic              req_sat,
    input  logic [HALF_W-1:0] req_a,
    input  logic [HALF_W-1:0] req_b,
    input  logic              clr,
    input  logic              wr_hi,
    input  logic              wr_lo,
    input  logic [HALF_W-1:0] wr_data,
    output logic              busy,
    output logic              done,
    output logic [HALF_W-1:0] acc_hi,
    output logic [HALF_W-1:0] acc_lo
);
    import mac_sat_pkg::*;

    localparam int EXT_W = HALF_W - WORD_W;

    mac_state_e          state, nxt;
    logic                op_word_q, sat_q;
    logic                mul_start, mul_fin;
    logic [HALF_W-1:0]   opa, opb, new_hi, new_lo;
    logic [2*HALF_W-1:0] prod;

    assign mul_start = (state == ST_IDLE) && req_valid;

    generate
        if (EXT_W > 0) begin : g_ext
            assign opa = req_word ? {{EXT_W{req_a[WORD_W-1]}}, req_a[WORD_W-1:0]} : req_a;
            assign opb = req_word ? {{EXT_W{req_b[WORD_W-1]}}, req_b[WORD_W-1:0]} : req_b;
        end else begin : g_noext
            assign opa = req_a;
            assign opb = req_b;
        end
    endgenerate

    mac_mul_iter #(.OP_W(HALF_W), .STEP_BITS(STEP_BITS)) i_mul (
        .clk   (clk),
        .rst_n (rst_n),
        .start (mul_start),
        .op_a  (opa),
        .op_b  (opb),
        .prod  (prod),
        .fin   (mul_fin)
    );

    mac_sat_logic #(.HALF_W(HALF_W)) i_sat (
        .acc_hi    (acc_hi),
        .acc_lo    (acc_lo),
        .prod      (prod),
        .word_mode (op_word_q),
        .sat_mode  (sat_q),
        .res_hi    (new_hi),
        .res_lo    (new_lo)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Next-state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (req_valid) nxt = ST_MUL;
            ST_MUL:  if (mul_fin)   nxt = ST_WB;
            ST_WB:                  nxt = ST_DONE;
            ST_DONE:                nxt = ST_IDLE;
            default:                nxt = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        busy = 1'b1;
        done = 1'b0;
        unique case (state)
            ST_IDLE: busy = 1'b0;
            ST_MUL:  ;
            ST_WB:   ;
            ST_DONE: done = 1'b1;
            default: busy = 1'b0;
        endcase
    end

    // Request attributes and accumulator
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_word_q <= 1'b0;
            sat_q     <= 1'b0;
            acc_hi    <= '0;
            acc_lo    <= '0;
        end else begin
            if (mul_start) begin
                op_word_q <= req_word;
                sat_q     <= req_sat;
            end
            if (state == ST_WB) begin
                acc_hi <= new_hi;
                acc_lo <= new_lo;
            end else if (state == ST_IDLE && !req_valid) begin
                if (clr) begin
                    acc_hi <= '0;
                    acc_lo <= '0;
                end else begin
                    if (wr_hi) acc_hi <= wr_data;
                    if (wr_lo) acc_lo <= wr_data;
                end
            end
        end
    end
endmodule

// File: rtl/mac_sat_checker.sv
module mac_sat_checker #(
    parameter int HALF_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              clr,
    input logic              busy,
    input logic              done,
    input logic [HALF_W-1:0] acc_hi,
    input logic [HALF_W-1:0] acc_lo
);
    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r10_done_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    a_r11_busy_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_valid));

    a_r8_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !busy && !req_valid) |=> (acc_hi == '0 && acc_lo == '0));

    a_r11_acc_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !$stable({acc_hi, acc_lo})) |-> done);
endmodule

bind mac_sat_unit mac_sat_checker #(.HALF_W(HALF_W)) i_mac_sat_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .clr       (clr),
    .busy      (busy),
    .done      (done),
    .acc_hi    (acc_hi),
    .acc_lo    (acc_lo)
);

// File: tb/test_mac_sat_unit.sv
`timescale 1ns/1ps
module test_mac_sat_unit;
    localparam int STEP = 4;
    localparam int LAT  = 32 / STEP + 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_word = 1'b0, req_sat = 1'b0;
    logic [31:0] req_a = '0, req_b = '0;
    logic        clr = 1'b0, wr_hi = 1'b0, wr_lo = 1'b0;
    logic [31:0] wr_data = '0;
    logic        busy, done;
    logic [31:0] acc_hi, acc_lo;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    mac_sat_unit #(.HALF_W(32), .WORD_W(16), .STEP_BITS(STEP)) i_mac_sat_unit (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_word(req_word),
        .req_sat(req_sat), .req_a(req_a), .req_b(req_b), .clr(clr),
        .wr_hi(wr_hi), .wr_lo(wr_lo), .wr_data(wr_data), .busy(busy),
        .done(done), .acc_hi(acc_hi), .acc_lo(acc_lo)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] ref_mac(input logic [63:0] acc, input bit word,
                                           input bit sat, input logic [31:0] a, input logic [31:0] b);
        longint pa, pb, s;
        logic [31:0] hi, lo;
        if (word) begin
            pa = longint'($signed(a[15:0]));
            pb = longint'($signed(b[15:0]));
        end else begin
            pa = longint'($signed(a));
            pb = longint'($signed(b));
        end
        s  = $signed(acc) + pa * pb;
        hi = s[63:32];
        lo = s[31:0];
        if (sat && !word) begin
            if (s < 0) hi = hi | 32'hFFFF0000;
            else       hi = hi & 32'h00007FFF;
        end else if (sat && word) begin
            if (s < -64'sd2147483648) begin hi = 32'd1; lo = 32'h80000000; end
            else if (s > 64'sd2147483647) begin hi = 32'd1; lo = 32'h7FFFFFFF; end
        end
        return {hi, lo};
    endfunction

    task automatic load_acc(input logic [31:0] hi, input logic [31:0] lo);
        @(negedge clk); wr_hi = 1'b1; wr_lo = 1'b0; wr_data = hi;
        @(negedge clk); wr_hi = 1'b0; wr_lo = 1'b1; wr_data = lo;
        @(negedge clk); wr_lo = 1'b0;
    endtask

    // Issue one request, check latency, single done, and result.
    task automatic run_op(input string tag, input bit word, input bit sat,
                          input logic [31:0] a, input logic [31:0] b);
        logic [63:0] exp;
        int n;
        exp = ref_mac({acc_hi, acc_lo}, word, sat, a, b);
        @(negedge clk);
        req_valid = 1'b1; req_word = word; req_sat = sat; req_a = a; req_b = b;
        @(negedge clk);
        req_valid = 1'b0;
        n = 0;
        while (!done && n < 100) begin @(negedge clk); n++; end
        check({tag, " R10 latency"}, 64'(n), 64'(LAT));
        check(tag, {acc_hi, acc_lo}, exp);
        @(negedge clk);
        check({tag, " R10 single done"}, 64'(done), 64'd0);
    endtask

    task automatic t_reset;
        check("R1 acc", {acc_hi, acc_lo}, 64'd0);
        check("R1 busy/done", {62'd0, busy, done}, 64'd0);
    endtask

    task automatic t_long_plain;
        load_acc(32'd0, 32'd10);
        run_op("R2 small", 1'b0, 1'b0, 32'd3, 32'hFFFFFFFB);
        check("R2 small value", {acc_hi, acc_lo}, 64'hFFFFFFFF_FFFFFFFB);
        load_acc(32'd0, 32'd0);
        run_op("R2 min*min", 1'b0, 1'b0, 32'h80000000, 32'h80000000);
        load_acc(32'h7FFFFFFF, 32'hFFFFFFFF);
        run_op("R2 wrap", 1'b0, 1'b0, 32'd1, 32'd1);
        check("R2 wrap value", {acc_hi, acc_lo}, 64'h80000000_00000000);
    endtask

    task automatic t_word_fields;
        load_acc(32'd0, 32'd0);
        run_op("R3 low bits", 1'b1, 1'b0, 32'hABCD8000, 32'h12340002);
        check("R3 value", {acc_hi, acc_lo}, 64'hFFFFFFFF_FFFF0000);
    endtask

    task automatic t_long_sat;
        load_acc(32'h12345678, 32'd0);
        run_op("R4 positive", 1'b0, 1'b1, 32'd1, 32'd1);
        check("R4 positive value", {acc_hi, acc_lo}, 64'h00005678_00000001);
        load_acc(32'h80001234, 32'd5);
        run_op("R4 negative", 1'b0, 1'b1, 32'd0, 32'd7);
        check("R4 negative value", {acc_hi, acc_lo}, 64'hFFFF1234_00000005);
    endtask

    task automatic t_word_sat;
        load_acc(32'hFFFFFFFF, 32'h80000000);
        run_op("R5 below", 1'b1, 1'b1, 32'h0000FFFF, 32'd1);
        check("R5 value", {acc_hi, acc_lo}, 64'h00000001_80000000);
        load_acc(32'd0, 32'h7FFFFFFF);
        run_op("R6 above", 1'b1, 1'b1, 32'd1, 32'd1);
        check("R6 value", {acc_hi, acc_lo}, 64'h00000001_7FFFFFFF);
        load_acc(32'd0, 32'd100);
        run_op("R7 in range", 1'b1, 1'b1, 32'd3, 32'd4);
        check("R7 in range value", {acc_hi, acc_lo}, 64'd112);
        load_acc(32'd0, 32'h7FFFFFFF);
        run_op("R7 no sat", 1'b1, 1'b0, 32'd1, 32'd1);
        check("R7 no sat value", {acc_hi, acc_lo}, 64'h00000000_80000000);
    endtask

    task automatic t_clear_write;
        load_acc(32'hAAAA5555, 32'h0F0F0F0F);
        check("R9 both halves", {acc_hi, acc_lo}, 64'hAAAA5555_0F0F0F0F);
        @(negedge clk); wr_hi = 1'b1; wr_data = 32'h13572468;
        @(negedge clk); wr_hi = 1'b0;
        check("R9 hi only", {acc_hi, acc_lo}, 64'h13572468_0F0F0F0F);
        @(negedge clk); clr = 1'b1; wr_hi = 1'b1; wr_lo = 1'b1; wr_data = 32'hDEADBEEF;
        @(negedge clk); clr = 1'b0; wr_hi = 1'b0; wr_lo = 1'b0;
        check("R8 clear priority", {acc_hi, acc_lo}, 64'd0);
    endtask

    task automatic t_busy_ignore;
        logic [63:0] exp;
        int n, dones;
        load_acc(32'd0, 32'd50);
        exp = ref_mac({acc_hi, acc_lo}, 1'b0, 1'b0, 32'd6, 32'd7);
        @(negedge clk);
        req_valid = 1'b1; req_word = 1'b0; req_sat = 1'b0; req_a = 32'd6; req_b = 32'd7;
        @(negedge clk);
        req_valid = 1'b0;
        n = 0; dones = 0;
        while (n < LAT + 4) begin
            clr = (n == 1); wr_hi = (n == 2); wr_lo = (n == 3); wr_data = 32'h99999999;
            req_valid = (n == 4); req_a = 32'd1000; req_b = 32'd1000;
            if (done) begin
                dones++;
                check("R11 result during busy", {acc_hi, acc_lo}, exp);
            end
            if (n >= LAT) begin clr = 1'b0; wr_hi = 1'b0; wr_lo = 1'b0; req_valid = 1'b0; end
            @(negedge clk); n++;
        end
        clr = 1'b0; wr_hi = 1'b0; wr_lo = 1'b0; req_valid = 1'b0;
        check("R11 single done", 64'(dones), 64'd1);
        check("R11 acc after", {acc_hi, acc_lo}, exp);
        check("R11 idle after", 64'(busy), 64'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_long_plain();
        t_word_fields();
        t_long_sat();
        t_word_sat();
        t_clear_write();
        t_busy_ignore();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule